// File: doc/BRIEF.md
# Verb-Addressed Scratch Mailbox with Display Interrupt

This block holds a 32-bit scratch mailbox inside an audio codec. An audio host reaches it through a simple command port. Each command carries a node ID, a 12-bit verb and an 8-bit payload. Byte-write verbs load one byte of the mailbox. A read verb returns the whole word on the following cycle. When the host publishes new content, a one-cycle interrupt pulse goes to the display-side controller.

The host uses a fixed convention for the contents. The two low bytes carry the 16-bit audio format word. The third byte is written as zero. Bit 30 marks the format as valid and is cleared when the host withdraws the format by writing a format of zero. The block stores these bits but does not interpret them.

Two mode inputs set how the block behaves:
- The trigger-mode input selects how an interrupt is signalled. In one scheme the host flips bit 31. In the other scheme the host writes a nonzero payload to a dedicated trigger verb.
- The per-converter input selects how mailboxes are addressed. Either one shared mailbox answers at the function-group node, or one mailbox per converter node answers at that converter's own node ID, each with its own interrupt line.

Top module: `scr_mailbox`

## Requirements
- R1: After reset every mailbox reads as zero, `irq_o` is all zero and `rsp_valid_o` is low.
- R2: A command with verb 0xFA6 to a matched node sets `rsp_valid_o` high for one cycle, on the cycle after the command, with `rsp_data_o` equal to the addressed mailbox as it was before that command.
- R3: Verb 0xFA7 loads the payload into bits [7:0] and verb 0xFA8 loads it into bits [15:8]. All other bits are left unchanged.
- R4: Verb 0xFA9 loads the payload into bits [23:16] and verb 0xFAA loads it into bits [31:24]. All other bits are left unchanged.
- R5: With `trig_mode_i`=0, a 0xFAA write whose payload bit 7 differs from the stored bit 31 pulses the mailbox's `irq_o` bit high for exactly the next cycle. A write that leaves bit 31 the same gives no pulse.
- R6: With `trig_mode_i`=0, verb 0xF80 has no effect on any mailbox or on `irq_o`.
- R7: With `trig_mode_i`=1, verb 0xF80 with a nonzero payload pulses the mailbox's `irq_o` bit on the next cycle. A zero payload gives no pulse. Verb 0xF80 changes no mailbox bits.
- R8: With `trig_mode_i`=1, changing bit 31 through verb 0xFAA raises no interrupt.
- R9: With `per_cvt_i`=0, only node ID `AFG_NID` (default 1) is matched. It addresses mailbox 0 and interrupt bit 0.
- R10: With `per_cvt_i`=1, node ID `CVT_NID_BASE`+i (default base 2) addresses mailbox i and interrupt bit i, for i from 0 to NUM_CVT-1. The function-group node is then unmatched.
- R11: A command to an unmatched node, or with any verb other than those listed, changes no mailbox and raises no interrupt. A 0xFA6 read to an unmatched node still returns `rsp_valid_o` high with `rsp_data_o` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_mode_i | input | 1 | 0: interrupt on a change of bit 31; 1: interrupt on the trigger verb |
| per_cvt_i | input | 1 | 0: one shared mailbox at the function-group node; 1: one mailbox per converter node |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_nid_i | input | NID_W | Target node ID |
| cmd_verb_i | input | 12 | Verb code |
| cmd_data_i | input | 8 | Payload byte |
| rsp_valid_o | output | 1 | Read response strobe |
| rsp_data_o | output | 32 | Read response word |
| irq_o | output | NUM_CVT | Per-mailbox one-cycle interrupt pulses |

## Verification
The assertions watch every cycle for three properties. A legacy-mode pulse must come with a real flip of bit 31. A trigger-mode pulse must follow a nonzero trigger verb. A mailbox nobody addressed must hold its value. They also check that a response appears only after a read verb, that at most one interrupt bit is high at a time, and that shared mode never uses the upper interrupt lines. Only the bench scenarios can show the rest: that each byte lands at the right position, that reads return the right data for every node ID in both addressing modes, and that a repeated bit-31 value or a zero trigger payload stays silent. The bench sweeps every node ID from 0 to 7 under all four mode combinations and compares against a model it computes itself.

// File: rtl/scr_mbx_pkg.sv
// Package: verb codes and decoded operation type shared by the mailbox.
// Assumes 12-bit verbs; byte-write verbs are consecutive codes.
package scr_mbx_pkg;
    localparam logic [11:0] VERB_READ = 12'hFA6;
    localparam logic [11:0] VERB_WB0  = 12'hFA7;
    localparam logic [11:0] VERB_WB1  = 12'hFA8;
    localparam logic [11:0] VERB_WB2  = 12'hFA9;
    localparam logic [11:0] VERB_WB3  = 12'hFAA;
    localparam logic [11:0] VERB_TRIG = 12'hF80;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_READ,
        OP_WB0,
        OP_WB1,
        OP_WB2,
        OP_WB3,
        OP_TRIG
    } scr_op_e;
endpackage

// File: rtl/scr_mbx_decode.sv
// Module: combinational command decoder.
// Maps node ID to a mailbox slot and verb to an operation.
// Assumes NID_W >= SLOT_W and that converter node IDs are contiguous.
module scr_mbx_decode
    import scr_mbx_pkg::*;
#(
    parameter int NUM_CVT      = 4,
    parameter int NID_W        = 8,
    parameter int AFG_NID      = 1,
    parameter int CVT_NID_BASE = 2,
    parameter int SLOT_W       = (NUM_CVT > 1) ? $clog2(NUM_CVT) : 1
) (
    input  logic              cmd_valid_i,
    input  logic [NID_W-1:0]  cmd_nid_i,
    input  logic [11:0]       cmd_verb_i,
    input  logic              per_cvt_i,
    output scr_op_e           op_o,
    output logic              hit_o,
    output logic [SLOT_W-1:0] slot_o
);
    logic [NID_W-1:0] offs;

    // Node match: shared mode answers at the function group, per-converter at a range.
    always_comb begin
        offs = cmd_nid_i - NID_W'(CVT_NID_BASE);
        if (per_cvt_i) begin
            hit_o  = (cmd_nid_i >= NID_W'(CVT_NID_BASE)) && (offs < NID_W'(NUM_CVT));
            slot_o = offs[SLOT_W-1:0];
        end else begin
            hit_o  = (cmd_nid_i == NID_W'(AFG_NID));
            slot_o = '0;
        end
    end

    // Verb decode: unknown verbs and idle cycles become OP_NONE.
    always_comb begin
        op_o = OP_NONE;
        if (cmd_valid_i) begin
            case (cmd_verb_i)
                VERB_READ: op_o = OP_READ;
                VERB_WB0:  op_o = OP_WB0;
                VERB_WB1:  op_o = OP_WB1;
                VERB_WB2:  op_o = OP_WB2;
                VERB_WB3:  op_o = OP_WB3;
                VERB_TRIG: op_o = OP_TRIG;
                default:   op_o = OP_NONE;
            endcase
        end
    end
endmodule

// File: rtl/scr_mbx_slot.sv
// Module: one 32-bit mailbox with byte writes and interrupt generation.
// Assumes the caller qualifies sel_i with a node match; op_i carries the verb.
module scr_mbx_slot
    import scr_mbx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sel_i,
    input  scr_op_e     op_i,
    input  logic [7:0]  data_i,
    input  logic        trig_mode_i,
    output logic [31:0] value_o,
    output logic        irq_o
);
    logic fire;

    // Trigger decision: bit-31 flip in legacy mode, nonzero trigger verb otherwise.
    always_comb begin
        fire = 1'b0;
        if (sel_i && !trig_mode_i && op_i == OP_WB3)
            fire = (data_i[7] != value_o[31]);
        if (sel_i && trig_mode_i && op_i == OP_TRIG)
            fire = (data_i != 8'h00);
    end

    // Mailbox storage: load the addressed byte lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_o <= '0;
        end else if (sel_i) begin
            case (op_i)
                OP_WB0:  value_o[7:0]   <= data_i;
                OP_WB1:  value_o[15:8]  <= data_i;
                OP_WB2:  value_o[23:16] <= data_i;
                OP_WB3:  value_o[31:24] <= data_i;
                default: value_o        <= value_o;
            endcase
        end
    end

    // Interrupt pulse register: high for the single cycle after a trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= fire;
    end

    AST_LEGACY_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !$past(trig_mode_i)) |-> (value_o[31] != $past(value_o[31]))); // R5
    AST_VERB_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && $past(trig_mode_i)) |-> ($past(op_i == OP_TRIG) && $past(data_i != 8'h00))); // R7
    AST_HOLD_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sel_i) |-> $stable(value_o)); // R11
endmodule

// File: rtl/scr_mailbox.sv
// Module: top of the scratch mailbox; decodes commands, holds one or
// NUM_CVT mailboxes, returns reads one cycle later and drives interrupts.
// Assumes at most one command per cycle; mode inputs are quasi-static.
module scr_mailbox
    import scr_mbx_pkg::*;
#(
    parameter int NUM_CVT      = 4,
    parameter int NID_W        = 8,
    parameter int AFG_NID      = 1,
    parameter int CVT_NID_BASE = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trig_mode_i,
    input  logic               per_cvt_i,
    input  logic               cmd_valid_i,
    input  logic [NID_W-1:0]   cmd_nid_i,
    input  logic [11:0]        cmd_verb_i,
    input  logic [7:0]         cmd_data_i,
    output logic               rsp_valid_o,
    output logic [31:0]        rsp_data_o,
    output logic [NUM_CVT-1:0] irq_o
);
    localparam int SLOT_W = (NUM_CVT > 1) ? $clog2(NUM_CVT) : 1;

    scr_op_e           op;
    logic              hit;
    logic [SLOT_W-1:0] slot;
    logic [31:0]       slot_val [NUM_CVT];

    scr_mbx_decode #(
        .NUM_CVT(NUM_CVT), .NID_W(NID_W), .AFG_NID(AFG_NID),
        .CVT_NID_BASE(CVT_NID_BASE), .SLOT_W(SLOT_W)
    ) u_decode (
        .cmd_valid_i(cmd_valid_i),
        .cmd_nid_i  (cmd_nid_i),
        .cmd_verb_i (cmd_verb_i),
        .per_cvt_i  (per_cvt_i),
        .op_o       (op),
        .hit_o      (hit),
        .slot_o     (slot)
    );

    for (genvar gi = 0; gi < NUM_CVT; gi++) begin : g_slot
        scr_mbx_slot u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .sel_i      (hit && (slot == SLOT_W'(gi))),
            .op_i       (op),
            .data_i     (cmd_data_i),
            .trig_mode_i(trig_mode_i),
            .value_o    (slot_val[gi]),
            .irq_o      (irq_o[gi])
        );
    end

    // Read response: registered word of the addressed slot, zero when unmatched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_o <= 1'b0;
            rsp_data_o  <= '0;
        end else begin
            rsp_valid_o <= (op == OP_READ);
            rsp_data_o  <= (op == OP_READ && hit) ? slot_val[slot] : 32'h0;
        end
    end

    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> ($past(cmd_valid_i) && $past(cmd_verb_i) == VERB_READ)); // R2
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_o)); // R10
    AST_SHARED_LINE0: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_o >> 1) != '0) |-> $past(per_cvt_i)); // R9
endmodule

// File: tb/scr_mailbox_bench.sv
// Bench: sweeps node IDs 0..7 under all mode combinations against a bench model.
module scr_mailbox_bench;
    localparam int N    = 4;
    localparam int AFG  = 1;
    localparam int BASE = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig_mode_i = 1'b0;
    logic        per_cvt_i = 1'b0;
    logic        cmd_valid_i = 1'b0;
    logic [7:0]  cmd_nid_i = '0;
    logic [11:0] cmd_verb_i = '0;
    logic [7:0]  cmd_data_i = '0;
    logic        rsp_valid_o;
    logic [31:0] rsp_data_o;
    logic [N-1:0] irq_o;

    int checks = 0;
    int failures = 0;
    logic [31:0] m [N];

    always #2 clk = ~clk;

    scr_mailbox u_scr_mailbox (
        .clk(clk), .rst_n(rst_n), .trig_mode_i(trig_mode_i), .per_cvt_i(per_cvt_i),
        .cmd_valid_i(cmd_valid_i), .cmd_nid_i(cmd_nid_i), .cmd_verb_i(cmd_verb_i),
        .cmd_data_i(cmd_data_i), .rsp_valid_o(rsp_valid_o), .rsp_data_o(rsp_data_o),
        .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic ev, input logic [31:0] ed,
                         input logic [N-1:0] ei);
        checks++;
        if (rsp_valid_o !== ev || rsp_data_o !== ed || irq_o !== ei) begin
            failures++;
            $display("FAIL %s: got rv=%0b rd=%08h irq=%b, expected rv=%0b rd=%08h irq=%b",
                     tag, rsp_valid_o, rsp_data_o, irq_o, ev, ed, ei);
        end
    endtask

    // Drive one command, update the model, check the outputs one cycle later.
    task automatic cmd(input string tag, input int nid, input logic [11:0] verb,
                       input logic [7:0] data);
        logic hit;
        int   s;
        logic ev;
        logic [31:0] ed;
        logic [N-1:0] ei;
        if (per_cvt_i) begin
            hit = (nid >= BASE) && (nid < BASE + N);
            s   = nid - BASE;
        end else begin
            hit = (nid == AFG);
            s   = 0;
        end
        ev = (verb == 12'hFA6);
        ed = (ev && hit) ? m[s] : 32'h0;
        ei = '0;
        if (hit) begin
            if (!trig_mode_i && verb == 12'hFAA && data[7] != m[s][31]) ei[s] = 1'b1;
            if (trig_mode_i && verb == 12'hF80 && data != 8'h00) ei[s] = 1'b1;
            case (verb)
                12'hFA7: m[s][7:0]   = data;
                12'hFA8: m[s][15:8]  = data;
                12'hFA9: m[s][23:16] = data;
                12'hFAA: m[s][31:24] = data;
                default: ;
            endcase
        end
        @(negedge clk);
        cmd_valid_i = 1'b1;
        cmd_nid_i   = nid[7:0];
        cmd_verb_i  = verb;
        cmd_data_i  = data;
        @(posedge clk);
        #1;
        check(tag, ev, ed, ei);
        @(negedge clk);
        cmd_valid_i = 1'b0;
        @(posedge clk);
        #1;
        check({tag, " idle R5"}, 1'b0, 32'h0, '0);
    endtask

    initial begin
        #(4ns * 150000);
        failures++;
        checks++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) m[i] = 32'h0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset outputs", 1'b0, 32'h0, '0);
        @(negedge clk);
        rst_n = 1'b1;
        cmd("R1 reset read", AFG, 12'hFA6, 8'h00);
        for (int pm = 0; pm < 4; pm++) begin
            per_cvt_i   = pm[1];
            trig_mode_i = pm[0];
            for (int nid = 0; nid < 8; nid++) begin
                logic [7:0] p;
                p = 8'((nid << 4) | pm);
                cmd(per_cvt_i ? "R10 wb0 R3" : "R9 wb0 R3", nid, 12'hFA7, p);
                cmd("R3 wb1", nid, 12'hFA8, ~p);
                cmd("R4 wb2", nid, 12'hFA9, 8'h00);
                cmd(trig_mode_i ? "R8 wb3 clear31" : "R5 wb3 clear31", nid, 12'hFAA, 8'h40);
                cmd("R2 read", nid, 12'hFA6, 8'h00);
                cmd(trig_mode_i ? "R8 wb3 set31" : "R5 wb3 set31", nid, 12'hFAA, 8'hC0);
                cmd(trig_mode_i ? "R8 wb3 same" : "R5 wb3 same", nid, 12'hFAA, 8'hC0);
                cmd(trig_mode_i ? "R7 trig zero" : "R6 trig zero", nid, 12'hF80, 8'h00);
                cmd(trig_mode_i ? "R7 trig one" : "R6 trig one", nid, 12'hF80, 8'(nid + 1));
                cmd("R11 unknown verb", nid, 12'hFAB, 8'hFF);
                cmd("R11 unknown verb", nid, 12'hF81, 8'hFF);
                cmd("R4 wb2 data", nid, 12'hFA9, p ^ 8'h5A);
            end
            for (int nid = 0; nid < 8; nid++)
                cmd(per_cvt_i ? "R10 R11 readback" : "R9 R11 readback", nid, 12'hFA6, 8'h00);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule